// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR graphics DRAM and brings the device from power-on to a usable state. After reset it keeps the clock-enable low and the command bus idle for a programmable stabilisation time. It then raises clock-enable and walks through a fixed list of commands: a precharge of all banks, an extended mode write that enables the DLL, a mode write that resets the DLL, a second precharge of all banks, a programmable number of auto-refreshes, and a final mode write with the DLL-reset bit cleared. Every wait is counted in clock cycles from parameters, and every gap is filled with NOP commands.

When the last wait has expired, and the DLL has had its lock time, the block raises a done flag that stays high until reset. From then on the surrounding controller can ask for a new mode-register value. The request is taken only when the controller reports that all banks are idle. The request is held off while a previous mode write is still in its settling window.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for T_STABLE cycles after reset falls, cke is 0 and the bus carries NOP. A synchronous reset at any point returns the block to this state.
- R2: cke rises in cycle T_STABLE after reset, together with a NOP. The first precharge-all follows T_CKE cycles later. cke then stays high.
- R3: Command encoding on (cs_n, ras_n, cas_n, we_n) is NOP = 0111, precharge = 0010, auto-refresh = 0001 and mode write = 0000. A precharge-all drives addr[10] = 1 and all other address bits 0. A mode write with ba = 1 targets the extended register and one with ba = 0 the main register. NOP and refresh drive ba = 0 and addr = 0.
- R4: The commands come in this order: precharge-all; extended mode write carrying EMRS_VAL; mode write carrying MRS_VAL with bit DLL_RST_BIT set; precharge-all; N_REF auto-refreshes; mode write carrying MRS_VAL with bit DLL_RST_BIT clear.
- R5: The next command follows a precharge after exactly T_RP cycles, a refresh after exactly T_RFC cycles, and a mode write after exactly T_MRD cycles. Only NOPs appear in between. Gap parameters below 2 are raised to 2, and N_REF below 2 is raised to 2.
- R6: init_done rises at the later of two cycles: the final mode write plus T_MRD, and the DLL-reset mode write plus T_DLL. It then stays high until reset.
- R7: A mode-write request (mrs_req) is acted on only after init_done is high and while banks_idle is 1. The mode write then appears in the next cycle with addr = mrs_data and ba = 0, and mrs_ack is high in that same cycle. A request made during initialization leaves the command schedule unchanged.
- R8: While banks_idle is 0, no request is taken and the bus stays at NOP. With a request held high, successive user mode writes are spaced exactly T_MRD + 1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_req | input | 1 | Request to write a new mode-register value |
| mrs_data | input | ADDR_W | Mode-register value for the request |
| banks_idle | input | 1 | All banks are precharged and idle |
| mrs_ack | output | 1 | High in the cycle the requested mode write is driven |
| init_done | output | 1 | Initialization complete |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |

## Verification
The bench uses the following parameters: a 10-cycle stabilisation wait, T_CKE = 2, T_RP = 3, T_MRD = 2, T_RFC = 5, three refreshes and a 30-cycle DLL lock time. With these values the whole power-up sequence fits in under 50 cycles, so every cycle can be compared against a schedule computed by adding up the gaps. Because the DLL lock time is the longer path, the done flag is set by the DLL wait and not by the final settling time. Three refreshes (one above the minimum) show that the refresh count is honoured. A 12-bit address bus carries the bit-10 precharge-all flag and the DLL-reset bit 8.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_CKEUP,
        ST_PREA1,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PREA2,
        ST_REF,
        ST_MRS_FIN,
        ST_GAP,
        ST_READY,
        ST_USR_MRS
    } state_e;

    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        case (c)
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int at_least(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         low
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign low = (cnt <= W'(1));

endmodule

// File: rtl/ddr_init_decode.sv
module ddr_init_decode
    import ddr_init_pkg::*;
#(
    parameter int                ADDR_W      = 13,
    parameter int                BA_W        = 2,
    parameter logic [ADDR_W-1:0] EMRS_VAL    = '0,
    parameter logic [ADDR_W-1:0] MRS_VAL     = '0,
    parameter int                DLL_RST_BIT = 8
) (
    input  state_e            st,
    input  logic [ADDR_W-1:0] usr_data,
    output logic              cke,
    output pins_t             pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << 10;
    localparam logic [BA_W-1:0]   BA_EXT    = BA_W'(1);

    cmd_e cmd;

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        case (st)
            ST_PREA1, ST_PREA2: begin
                cmd  = CMD_PRE;
                addr = PREA_ADDR;
            end
            ST_EMRS: begin
                cmd  = CMD_MRS;
                ba   = BA_EXT;
                addr = EMRS_VAL;
            end
            ST_MRS_DLL: begin
                cmd  = CMD_MRS;
                addr = MRS_VAL | DLL_MASK;
            end
            ST_MRS_FIN: begin
                cmd  = CMD_MRS;
                addr = MRS_VAL & ~DLL_MASK;
            end
            ST_REF: cmd = CMD_REF;
            ST_USR_MRS: begin
                cmd  = CMD_MRS;
                addr = usr_data;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign pins = encode_cmd(cmd);
    assign cke  = (st != ST_PWR);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int                ADDR_W      = 13,
    parameter int                BA_W        = 2,
    parameter int                T_STABLE    = 20000,
    parameter int                T_CKE       = 2,
    parameter int                T_RP        = 3,
    parameter int                T_MRD       = 2,
    parameter int                T_RFC       = 15,
    parameter int                T_DLL       = 200,
    parameter int                N_REF       = 2,
    parameter logic [ADDR_W-1:0] EMRS_VAL    = '0,
    parameter logic [ADDR_W-1:0] MRS_VAL     = ADDR_W'(12'h032),
    parameter int                DLL_RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_req,
    input  logic [ADDR_W-1:0] mrs_data,
    input  logic              banks_idle,
    output logic              mrs_ack,
    output logic              init_done,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam int STABLE_C = at_least(T_STABLE, 1);
    localparam int CKE_C    = at_least(T_CKE, 2);
    localparam int RP_C     = at_least(T_RP, 2);
    localparam int MRD_C    = at_least(T_MRD, 2);
    localparam int RFC_C    = at_least(T_RFC, 2);
    localparam int DLL_C    = at_least(T_DLL, 1);
    localparam int REF_C    = at_least(N_REF, 2);
    localparam int MAX_GAP  = max_of(max_of(CKE_C, RP_C), max_of(MRD_C, RFC_C));
    localparam int CNT_W    = $clog2(max_of(STABLE_C, MAX_GAP) + 1);
    localparam int DLL_W    = $clog2(DLL_C + 1);
    localparam int REF_W    = $clog2(REF_C + 1);

    localparam logic [CNT_W-1:0] CKE_LD = CNT_W'(CKE_C - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_C - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_C - 1);
    localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(RFC_C - 1);
    localparam logic [DLL_W-1:0] DLL_LD = DLL_W'(DLL_C - 1);

    state_e             st, st_d, ret, ret_d;
    logic               gap_load, dll_load;
    logic [CNT_W-1:0]   gap_val, gap_cnt;
    logic [DLL_W-1:0]   dll_cnt;
    logic               gap_low, dll_low;
    logic [REF_W-1:0]   ref_left;
    logic               done_q;
    pins_t              pins;

    ddr_init_timer #(
        .W       (CNT_W),
        .RST_VAL (CNT_W'(STABLE_C))
    ) u_gap_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .cnt      (gap_cnt),
        .low      (gap_low)
    );

    ddr_init_timer #(
        .W       (DLL_W),
        .RST_VAL ('0)
    ) u_dll_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (dll_load),
        .load_val (DLL_LD),
        .cnt      (dll_cnt),
        .low      (dll_low)
    );

    always_comb begin
        st_d     = st;
        ret_d    = ret;
        gap_load = 1'b0;
        gap_val  = '0;
        dll_load = 1'b0;
        case (st)
            ST_PWR: begin
                if (gap_low) st_d = ST_CKEUP;
            end
            ST_CKEUP: begin
                gap_load = 1'b1;
                gap_val  = CKE_LD;
                ret_d    = ST_PREA1;
                st_d     = ST_GAP;
            end
            ST_PREA1: begin
                gap_load = 1'b1;
                gap_val  = RP_LD;
                ret_d    = ST_EMRS;
                st_d     = ST_GAP;
            end
            ST_EMRS: begin
                gap_load = 1'b1;
                gap_val  = MRD_LD;
                ret_d    = ST_MRS_DLL;
                st_d     = ST_GAP;
            end
            ST_MRS_DLL: begin
                gap_load = 1'b1;
                gap_val  = MRD_LD;
                dll_load = 1'b1;
                ret_d    = ST_PREA2;
                st_d     = ST_GAP;
            end
            ST_PREA2: begin
                gap_load = 1'b1;
                gap_val  = RP_LD;
                ret_d    = ST_REF;
                st_d     = ST_GAP;
            end
            ST_REF: begin
                gap_load = 1'b1;
                gap_val  = RFC_LD;
                ret_d    = (ref_left == REF_W'(1)) ? ST_MRS_FIN : ST_REF;
                st_d     = ST_GAP;
            end
            ST_MRS_FIN, ST_USR_MRS: begin
                gap_load = 1'b1;
                gap_val  = MRD_LD;
                ret_d    = ST_READY;
                st_d     = ST_GAP;
            end
            ST_GAP: begin
                if (gap_low && (ret != ST_READY || dll_low)) st_d = ret;
            end
            ST_READY: begin
                if (mrs_req && banks_idle) st_d = ST_USR_MRS;
            end
            default: st_d = ST_PWR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_PWR;
            ret      <= ST_PREA1;
            ref_left <= REF_W'(REF_C);
            done_q   <= 1'b0;
        end else begin
            st  <= st_d;
            ret <= ret_d;
            if (st == ST_REF) ref_left <= ref_left - REF_W'(1);
            if (st == ST_READY) done_q <= 1'b1;
        end
    end

    ddr_init_decode #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .EMRS_VAL    (EMRS_VAL),
        .MRS_VAL     (MRS_VAL),
        .DLL_RST_BIT (DLL_RST_BIT)
    ) u_dec (
        .st       (st),
        .usr_data (mrs_data),
        .cke      (cke),
        .pins     (pins),
        .ba       (ba),
        .addr     (addr)
    );

    assign cs_n      = pins.cs_n;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;
    assign init_done = done_q || (st == ST_READY);
    assign mrs_ack   = (st == ST_USR_MRS);

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mrs_req,
    input logic              banks_idle,
    input logic              mrs_ack,
    input logic              init_done,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr
);

    logic [3:0] bus;
    assign bus = {cs_n, ras_n, cas_n, we_n};

    AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (rst)
        !cke |-> bus == 4'b0111); // R1

    AST_CKE_STICKY: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke); // R2

    generate
        if (ADDR_W > 10) begin : g_a10
            AST_PREA_A10: assert property (@(posedge clk) disable iff (rst)
                bus == 4'b0010 |-> addr[10]); // R3
        end
    endgenerate

    AST_MR_GAP: assert property (@(posedge clk) disable iff (rst)
        bus == 4'b0000 |=> bus == 4'b0111); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R6

    AST_DONE_CKE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> cke); // R6

    AST_ACK_MRS: assert property (@(posedge clk) disable iff (rst)
        mrs_ack |-> (bus == 4'b0000 && ba == '0)); // R7

    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mrs_ack |-> $past(mrs_req && banks_idle && init_done)); // R7

endmodule

bind ddr_init_seq ddr_init_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mrs_req    (mrs_req),
    .banks_idle (banks_idle),
    .mrs_ack    (mrs_ack),
    .init_done  (init_done),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;

    localparam int AW   = 12;
    localparam int BW   = 2;
    localparam int S    = 10;
    localparam int CK   = 2;
    localparam int RP   = 3;
    localparam int MRD  = 2;
    localparam int RFC  = 5;
    localparam int DLL  = 30;
    localparam int NREF = 3;
    localparam logic [AW-1:0] EMRS_V = 12'h000;
    localparam logic [AW-1:0] MRS_V  = 12'h032;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mrs_req = 1'b0;
    logic [AW-1:0] mrs_data = '0;
    logic          banks_idle = 1'b0;
    logic          mrs_ack, init_done, cke, cs_n, ras_n, cas_n, we_n;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int n_run  = 0;
    int n_fail = 0;

    always #10ns clk = ~clk;

    ddr_init_seq #(
        .ADDR_W (AW), .BA_W (BW), .T_STABLE (S), .T_CKE (CK), .T_RP (RP),
        .T_MRD (MRD), .T_RFC (RFC), .T_DLL (DLL), .N_REF (NREF),
        .EMRS_VAL (EMRS_V), .MRS_VAL (MRS_V), .DLL_RST_BIT (8)
    ) u0 (
        .clk (clk), .rst (rst), .mrs_req (mrs_req), .mrs_data (mrs_data),
        .banks_idle (banks_idle), .mrs_ack (mrs_ack), .init_done (init_done),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr)
    );

    // schedule computed from the gap rules
    localparam int T_P1   = S + CK;
    localparam int T_E    = T_P1 + RP;
    localparam int T_MD   = T_E + MRD;
    localparam int T_P2   = T_MD + MRD;
    localparam int T_R0   = T_P2 + RP;
    localparam int T_FIN  = T_R0 + NREF * RFC;
    localparam int T_DONE = ((T_FIN + MRD) > (T_MD + DLL)) ? (T_FIN + MRD) : (T_MD + DLL);

    // packed view: cke, bus[3:0], ba, addr, done, ack
    function automatic logic [AW+BW+6:0] pack(logic k, logic [3:0] b, logic [BW-1:0] bb,
                                              logic [AW-1:0] a, logic d, logic ak);
        return {k, b, bb, a, d, ak};
    endfunction

    function automatic logic [AW+BW+6:0] observed();
        return pack(cke, {cs_n, ras_n, cas_n, we_n}, ba, addr, init_done, mrs_ack);
    endfunction

    task automatic check(string tag, int t, logic [AW+BW+6:0] got, logic [AW+BW+6:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d got=%h exp=%h", tag, t, got, exp);
        end
    endtask

    // expected outputs during the power-up sweep at cycle t
    task automatic expect_init(int t, output string tag, output logic [AW+BW+6:0] e);
        logic [3:0]    b  = 4'b0111;
        logic [BW-1:0] bb = '0;
        logic [AW-1:0] a  = '0;
        tag = "R5";
        if (t < S) tag = "R1";
        else if (t == S) tag = "R2";
        if (t == T_P1 || t == T_P2) begin
            b = 4'b0010; a = 12'h400; tag = "R3";
        end else if (t == T_E) begin
            b = 4'b0000; bb = 2'd1; a = EMRS_V; tag = "R4";
        end else if (t == T_MD) begin
            b = 4'b0000; a = MRS_V | 12'h100; tag = "R4";
        end else if (t == T_FIN) begin
            b = 4'b0000; a = MRS_V & ~12'h100; tag = "R4";
        end else if (t >= T_R0 && t < T_FIN && ((t - T_R0) % RFC) == 0) begin
            b = 4'b0001; tag = "R3";
        end
        if (t >= T_DONE - 1 && t <= T_DONE) tag = "R6";
        e = pack(t >= S, b, bb, a, t >= T_DONE, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", -1, {cke, cs_n, ras_n, cas_n, we_n, init_done},
                  {1'b0, 4'b0111, 1'b0});
        end
        rst = 1'b0;
    endtask

    // sweep from reset release up to last_t inclusive (caller is at a negedge)
    task automatic sweep(int last_t);
        string tag;
        logic [AW+BW+6:0] e;
        for (int t = 0; t <= last_t; t++) begin
            expect_init(t, tag, e);
            check(tag, t, observed(), e);
            if (t != last_t) @(negedge clk);
        end
    endtask

    initial begin : main
        // run 1: abort mid-way through the refreshes, no requests
        do_reset();
        sweep(T_R0 + 1);
        @(negedge clk);
        // run 2: full sweep with a request pending during init (R7 ignored early)
        mrs_req    = 1'b1;
        banks_idle = 1'b1;
        mrs_data   = 12'h5A5;
        do_reset();
        sweep(T_DONE);
        // request accepted on the edge after T_DONE
        @(negedge clk);
        check("R7", T_DONE + 1, observed(),
              pack(1'b1, 4'b0000, 2'd0, 12'h5A5, 1'b1, 1'b1));
        // held request: acks spaced MRD+1 apart, NOP between (R8)
        for (int k = 1; k <= 4 * (MRD + 1); k++) begin
            @(negedge clk);
            if ((k % (MRD + 1)) == 0)
                check("R8", k, observed(), pack(1'b1, 4'b0000, 2'd0, 12'h5A5, 1'b1, 1'b1));
            else
                check("R8", k, observed(), pack(1'b1, 4'b0111, 2'd0, 12'h000, 1'b1, 1'b0));
        end
        // hold off while banks busy (R8)
        banks_idle = 1'b0;
        repeat (MRD + 2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            mrs_data = 12'(k * 12'h111);
            check("R8", k, observed(), pack(1'b1, 4'b0111, 2'd0, 12'h000, 1'b1, 1'b0));
            @(negedge clk);
        end
        // banks become idle: accepted with the present data
        mrs_data   = 12'h3C1;
        banks_idle = 1'b1;
        @(negedge clk);
        mrs_req = 1'b0;
        check("R7", 0, observed(), pack(1'b1, 4'b0000, 2'd0, 12'h3C1, 1'b1, 1'b1));
        repeat (MRD + 3) @(negedge clk);
        check("R7", 1, observed(), pack(1'b1, 4'b0111, 2'd0, 12'h000, 1'b1, 1'b0));
        // reset from the ready state returns to the CKE-low wait (R1)
        do_reset();
        sweep(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(20ns * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule